// File: doc/BRIEF.md
# Event Pattern Pulser

The pulser replays stored test events on demand. A host loads a 36-bit-wide pattern memory through a simple write port. The memory is split into four equal event regions, and the two top address bits select the region. When a trigger-accept pulse arrives with a 2-bit region number, the block queues the event. It reads that region's first word as a header, which carries the event's own output latency. It then copies the following words into an output FIFO until it reaches a word flagged as trailer.

A separate output controller releases the queued words as 32-bit output words, four byte lanes side by side. It does so only once the event's latency counter, started at its accept, has reached the header value. Words leave at a programmable pace of one word per `rate_div` core clocks. Because filling and sending are independent, the next event is usually already in the FIFO while the current one drains. Up to four events may be outstanding; further accepts are dropped and flagged.

The output is a valid/ready stream. A word is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` is held unchanged and no word is skipped. Back-pressure only delays the stream. It never changes its content or order. The pacing interval restarts from the cycle a word is first presented, so a consumer that stalls longer than the interval receives the next word on the following edge.

Top module: `evpulse_top`

## Requirements
- R1: After reset, `out_valid` is low, `acc_ovf` is low and `trl_info` is zero.
- R2: A memory word holds lane bytes in bits 31:0, with lane k in bits 8k+7:8k. Bit 35 flags a header, bit 34 a trailer and bit 33 a gap; bit 32 is unused. The word address is {region[1:0], offset}, and offset 0 of each region is the header. Header bits 15:0 give the latency L in core clocks.
- R3: For each accepted event, the data words that follow the header are presented on `out_data` in memory order. Each appears exactly once, and none of the header, gap or trailer words appears.
- R4: If an event is accepted while the block is idle and L >= 3, its first data word is presented exactly L+1 clock edges after the edge that sampled the accept.
- R5: If an event with L = 0 is accepted while the block is idle, its first data word is presented no later than 4 edges after the accept.
- R6: A gap-flagged word is not sent. The output holds `out_valid` low for one extra pacing slot at that point.
- R7: When a trailer is reached, its bits 31:0 appear on `trl_info` and remain there until the next trailer.
- R8: With `rate_div` = N >= 1 and no back-pressure, successive words of an event are presented at least N cycles apart. N = 0 behaves as N = 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. No word is lost or duplicated under back-pressure.
- R10: Events are sent in accept order, each after its own latency. A later event is filled while an earlier one drains. Its first word follows the earlier event's last word within 2 cycles once its own latency has expired.
- R11: An accept that arrives while four events are pending is dropped. It sets `acc_ovf`, which stays high until reset.
- R12: If a region has no trailer, its last word (offset all ones) ends the event and is treated as the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Pattern memory write enable |
| ld_addr | input | ADDR_W | Pattern memory write address {region, offset} |
| ld_word | input | 36 | Pattern memory write data |
| acc_in | input | 1 | Trigger-accept pulse, one cycle per event |
| acc_buf | input | 2 | Region number of the accepted event |
| rate_div | input | RATE_W | Core clocks per output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Four output byte lanes |
| trl_info | output | 32 | Payload of the most recent trailer |
| acc_ovf | output | 1 | Sticky dropped-accept flag |

## Verification
The bench uses the default parameters. An 8-bit address gives 64-word regions, so a region with no trailer can be walked to its last offset within a short run. A four-entry event queue lets five back-to-back accepts reach the drop path. A 16-entry FIFO is smaller than that 62-word event, so with a two-clock pace the filler must stall on a full FIFO. A 16-bit latency field allows latencies of 20 and 40 cycles, so two overlapping events with different latencies can be ordered and timed against each other.

// File: rtl/evp_pkg.sv
package evp_pkg;
  localparam int WORD_W  = 36;
  localparam int PAY_W   = 32;
  localparam int TRL_BIT = 34;
  localparam int GAP_BIT = 33;

  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_GAP  = 2'd1,
    K_END  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [PAY_W-1:0] data;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/evp_fifo.sv
module evp_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_C = DEPTH[AW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (cnt == FULL_C);
  assign empty   = (cnt == '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/evp_sched.sv
module evp_sched #(
  parameter int EVQ   = 4,
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [1:0]       trig_buf,
  input  logic             hdr_we,
  input  logic [LAT_W-1:0] hdr_lat,
  input  logic             fill_done,
  input  logic             ev_done,
  output logic             fill_req,
  output logic [1:0]       fill_buf,
  output logic             head_rel,
  output logic             ovf
);
  localparam int PW = $clog2(EVQ);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_C = EVQ[CW-1:0];

  logic [1:0]       sbuf [EVQ];
  logic [LAT_W-1:0] sage [EVQ];
  logic [LAT_W-1:0] slat [EVQ];
  logic [EVQ-1:0]   sok;
  logic [PW-1:0]    wp, fp, rp;
  logic [CW-1:0]    cnt, ucnt;
  logic             q_full, acc;

  assign q_full   = (cnt == FULL_C);
  assign acc      = trig && !q_full;
  assign fill_req = (ucnt != '0);
  assign fill_buf = sbuf[fp];
  assign head_rel = (cnt != '0) && sok[rp] && (sage[rp] >= slat[rp]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < EVQ; i++) begin
        sbuf[i] <= '0;
        sage[i] <= '0;
        slat[i] <= '0;
      end
      sok  <= '0;
      wp   <= '0;
      fp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ucnt <= '0;
      ovf  <= 1'b0;
    end else begin
      for (int i = 0; i < EVQ; i++) begin
        if (acc && wp == PW'(i)) begin
          sbuf[i] <= trig_buf;
          sage[i] <= '0;
          sok[i]  <= 1'b0;
        end else begin
          if (sage[i] != '1) sage[i] <= sage[i] + 1'b1;
          if (hdr_we && fp == PW'(i)) begin
            slat[i] <= hdr_lat;
            sok[i]  <= 1'b1;
          end
        end
      end
      if (acc)       wp <= wp + 1'b1;
      if (fill_done) fp <= fp + 1'b1;
      if (ev_done)   rp <= rp + 1'b1;
      cnt  <= cnt + CW'(acc) - CW'(ev_done);
      ucnt <= ucnt + CW'(acc) - CW'(fill_done);
      if (trig && q_full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/evp_fill.sv
module evp_fill
  import evp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_req,
  input  logic [1:0]        fill_buf,
  output logic              mem_ren,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              fifo_full,
  output logic              fifo_push,
  output ent_t              fifo_din,
  output logic              hdr_we,
  output logic [LAT_W-1:0]  hdr_lat,
  output logic              fill_done,
  output logic [PAY_W-1:0]  trl_info
);
  localparam int OW = ADDR_W - 2;

  typedef enum logic [1:0] {F_IDLE, F_HDR, F_DATA} fst_e;

  fst_e          st;
  logic [OW-1:0] ptr;
  logic [1:0]    bsel;
  logic          is_trl;
  logic          unused_flags;

  assign unused_flags = ^{mem_rdata[WORD_W-1], mem_rdata[PAY_W]};
  assign hdr_lat      = mem_rdata[LAT_W-1:0];
  assign is_trl       = mem_rdata[TRL_BIT] || (ptr == '0);

  always_comb begin
    mem_ren   = 1'b0;
    mem_addr  = {bsel, ptr};
    fifo_push = 1'b0;
    fifo_din  = '{kind: K_DATA, data: mem_rdata[PAY_W-1:0]};
    hdr_we    = 1'b0;
    fill_done = 1'b0;
    unique case (st)
      F_IDLE: begin
        if (fill_req) begin
          mem_ren  = 1'b1;
          mem_addr = {fill_buf, {OW{1'b0}}};
        end
      end
      F_HDR: begin
        hdr_we  = 1'b1;
        mem_ren = 1'b1;
      end
      F_DATA: begin
        if (!fifo_full) begin
          fifo_push = 1'b1;
          if (is_trl) begin
            fifo_din.kind = K_END;
            fill_done     = 1'b1;
          end else begin
            if (mem_rdata[GAP_BIT]) fifo_din.kind = K_GAP;
            mem_ren = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      ptr      <= '0;
      bsel     <= '0;
      trl_info <= '0;
    end else begin
      unique case (st)
        F_IDLE: begin
          if (fill_req) begin
            bsel <= fill_buf;
            ptr  <= {{(OW-1){1'b0}}, 1'b1};
            st   <= F_HDR;
          end
        end
        F_HDR: begin
          ptr <= ptr + 1'b1;
          st  <= F_DATA;
        end
        F_DATA: begin
          if (!fifo_full) begin
            if (is_trl) begin
              trl_info <= mem_rdata[PAY_W-1:0];
              st       <= F_IDLE;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evp_out.sv
module evp_out
  import evp_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              head_rel,
  input  logic              ent_valid,
  input  ent_t              ent,
  output logic              ent_pop,
  output logic              ev_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAY_W-1:0]  out_data
);
  logic [RATE_W-1:0] dv, reload;
  logic              act;

  assign reload  = (rate == '0) ? '0 : rate - RATE_W'(1);
  assign act     = (dv == '0) && (!out_valid || out_ready);
  assign ent_pop = act && head_rel && ent_valid;
  assign ev_done = ent_pop && (ent.kind == K_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      dv        <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (dv != '0) dv <= dv - 1'b1;
      if (ent_pop) begin
        unique case (ent.kind)
          K_DATA: begin
            out_valid <= 1'b1;
            out_data  <= ent.data;
            dv        <= reload;
          end
          K_GAP:   dv <= reload;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/evpulse_top.sv
module evpulse_top
  import evp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 16,
  parameter int EVQ    = 4,
  parameter int FIFO_D = 16,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [35:0]       ld_word,
  input  logic              acc_in,
  input  logic [1:0]        acc_buf,
  input  logic [RATE_W-1:0] rate_div,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [31:0]       trl_info,
  output logic              acc_ovf
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] pmem [DEPTH];
  logic [WORD_W-1:0] m_rdata;
  logic [ADDR_W-1:0] m_addr;
  logic              m_ren;

  logic              fill_req, fill_done, hdr_we, head_rel, ev_done;
  logic [1:0]        fill_buf;
  logic [LAT_W-1:0]  hdr_lat;
  logic              f_push, f_pop, f_full, f_empty;
  ent_t              f_din, f_ent;
  logic [ENT_W-1:0]  f_dout;

  assign f_ent = ent_t'(f_dout);

  always_ff @(posedge clk) begin
    if (ld_en) pmem[ld_addr] <= ld_word;
    if (m_ren) m_rdata <= pmem[m_addr];
  end

  evp_sched #(.EVQ(EVQ), .LAT_W(LAT_W)) i_sched (
    .clk(clk), .rst_n(rst_n), .trig(acc_in), .trig_buf(acc_buf),
    .hdr_we(hdr_we), .hdr_lat(hdr_lat), .fill_done(fill_done),
    .ev_done(ev_done), .fill_req(fill_req), .fill_buf(fill_buf),
    .head_rel(head_rel), .ovf(acc_ovf)
  );

  evp_fill #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_fill (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_buf(fill_buf),
    .mem_ren(m_ren), .mem_addr(m_addr), .mem_rdata(m_rdata),
    .fifo_full(f_full), .fifo_push(f_push), .fifo_din(f_din),
    .hdr_we(hdr_we), .hdr_lat(hdr_lat), .fill_done(fill_done),
    .trl_info(trl_info)
  );

  evp_fifo #(.W(ENT_W), .DEPTH(FIFO_D)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .din(f_din),
    .pop(f_pop), .dout(f_dout), .full(f_full), .empty(f_empty)
  );

  evp_out #(.RATE_W(RATE_W)) i_out (
    .clk(clk), .rst_n(rst_n), .rate(rate_div), .head_rel(head_rel),
    .ent_valid(!f_empty), .ent(f_ent), .ent_pop(f_pop), .ev_done(ev_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/evp_chk.sv
module evp_chk #(
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic [RATE_W-1:0] rate_div,
  input logic              acc_ovf,
  input logic              f_push,
  input logic              f_full,
  input logic              f_pop,
  input logic              f_empty
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ovf |=> acc_ovf);

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_push |-> !f_full);

  assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_pop |-> !f_empty);

  assert_pace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_ready && (rate_div > RATE_W'(1)) && $stable(rate_div))
      |=> !out_valid);
endmodule

bind evpulse_top evp_chk #(.RATE_W(RATE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .rate_div(rate_div), .acc_ovf(acc_ovf),
  .f_push(f_push), .f_full(f_full), .f_pop(f_pop), .f_empty(f_empty)
);

// File: tb/test_evpulse_top.sv
`timescale 1ns/1ps
module test_evpulse_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [35:0] ld_word;
  logic        acc_in;
  logic [1:0]  acc_buf;
  logic [7:0]  rate_div;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [31:0] trl_info;
  logic        acc_ovf;

  evpulse_top i_evpulse_top (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_word(ld_word), .acc_in(acc_in), .acc_buf(acc_buf),
    .rate_div(rate_div), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .trl_info(trl_info), .acc_ovf(acc_ovf)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] d;
    int          mode;   // 0 none, 1 min spacing, 2 exact cycle, 3 latest cycle, 4 max spacing
    int          refc;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t e;
  int   cyc = 0;
  int   lastc = 0;
  int   errs = 0;
  int   checks = 0;
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] dw(input int b, input int k);
    return {8'(b + 8'h10), 8'(k), 8'(~k), 8'hA5};
  endfunction

  task automatic put(input int b, input int off, input logic [3:0] ctl, input logic [31:0] pay);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_addr = {2'(b), 6'(off)};
    ld_word = {ctl, pay};
  endtask

  task automatic expect_w(input logic [31:0] d, input int mode, input int refc, input string req);
    exp_t x;
    x.d = d; x.mode = mode; x.refc = refc; x.req = req;
    sb.push_back(x);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (sb.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(1'b0, "R3 drain timeout", sb.size(), 0);
    repeat (20) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n) out_ready <= 1'b1;
    else        out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3 unexpected word", out_data, 0);
      end else begin
        e = sb.pop_front();
        chk(out_data == e.d, e.req, out_data, e.d);
        if (e.mode == 1) chk((cyc - lastc) >= e.refc, {e.req, " min spacing"}, cyc - lastc, e.refc);
        if (e.mode == 2) chk(cyc == e.refc, {e.req, " exact cycle"}, cyc, e.refc);
        if (e.mode == 3) chk(cyc <= e.refc, {e.req, " latest cycle"}, cyc, e.refc);
        if (e.mode == 4) chk((cyc - lastc) <= e.refc, {e.req, " max spacing"}, cyc - lastc, e.refc);
      end
      lastc = cyc;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int tc;
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_word = '0;
    acc_in = 1'b0; acc_buf = '0; rate_div = 8'd1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(acc_ovf == 1'b0, "R1 acc_ovf after reset", acc_ovf, 0);
    chk(trl_info == 32'h0, "R1 trl_info after reset", trl_info, 0);
    rst_n = 1'b1;

    // R2: memory layout, header bit 35, trailer bit 34, gap bit 33
    put(0, 0, 4'b1000, 32'd20);
    for (int k = 1; k <= 3; k++) put(0, k, 4'b0000, dw(0, k));
    put(0, 4, 4'b0100, 32'hCAFE0000);
    put(1, 0, 4'b1000, 32'd0);
    put(1, 1, 4'b0000, dw(1, 1));
    put(1, 2, 4'b0010, 32'hDEADDEAD);
    put(1, 3, 4'b0000, dw(1, 3));
    put(1, 4, 4'b0100, 32'h00001111);
    put(2, 0, 4'b1000, 32'd40);
    for (int k = 1; k <= 5; k++) put(2, k, 4'b0000, dw(2, k));
    put(2, 6, 4'b0100, 32'h22222222);
    put(3, 0, 4'b1000, 32'd5);
    for (int k = 1; k <= 62; k++) put(3, k, 4'b0000, dw(3, k));
    put(3, 63, 4'b0000, 32'h3F3F3F3F);
    @(negedge clk);
    ld_en = 1'b0;
    repeat (4) @(negedge clk);

    // R4 and R3: latency 20, idle start
    tc = cyc + 1;
    expect_w(dw(0, 1), 2, tc + 21, "R4 first word at L+1");
    expect_w(dw(0, 2), 0, 0, "R3 word order");
    expect_w(dw(0, 3), 0, 0, "R3 word order");
    acc_in = 1'b1; acc_buf = 2'd0;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();
    chk(trl_info == 32'hCAFE0000, "R7 trailer payload", trl_info, 32'hCAFE0000);

    // R5 and R6: latency zero, gap word in the middle
    tc = cyc + 1;
    expect_w(dw(1, 1), 3, tc + 4, "R5 latency zero");
    expect_w(dw(1, 3), 1, 2, "R6 gap slot");
    acc_in = 1'b1; acc_buf = 2'd1;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();
    chk(trl_info == 32'h00001111, "R7 trailer payload update", trl_info, 32'h00001111);

    // R8: pacing at three clocks per word
    rate_div = 8'd3;
    tc = cyc + 1;
    expect_w(dw(2, 1), 2, tc + 41, "R4 first word at L+1 (L=40)");
    for (int k = 2; k <= 5; k++) expect_w(dw(2, k), 1, 3, "R8 pacing");
    acc_in = 1'b1; acc_buf = 2'd2;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();
    rate_div = 8'd0;

    // R9: random back-pressure, rate 0 treated as 1
    bp_en = 1'b1;
    for (int k = 1; k <= 5; k++) expect_w(dw(2, k), 0, 0, "R9 back-pressure");
    for (int k = 1; k <= 3; k++) expect_w(dw(0, k), 0, 0, "R9 back-pressure");
    acc_in = 1'b1; acc_buf = 2'd2;
    @(negedge clk);
    acc_buf = 2'd0;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();
    bp_en = 1'b0;
    rate_div = 8'd1;

    // R10: second event prefilled while first drains
    for (int k = 1; k <= 5; k++) expect_w(dw(2, k), 0, 0, "R10 order first event");
    expect_w(dw(0, 1), 4, 2, "R10 prefilled second event");
    for (int k = 2; k <= 3; k++) expect_w(dw(0, k), 0, 0, "R10 order second event");
    acc_in = 1'b1; acc_buf = 2'd2;
    @(negedge clk);
    acc_buf = 2'd0;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();

    // R11: five back-to-back accepts, the fifth is dropped
    chk(acc_ovf == 1'b0, "R11 flag clear before overflow", acc_ovf, 0);
    for (int j = 0; j < 5; j++) begin
      if (j < 4) for (int k = 1; k <= 3; k++) expect_w(dw(0, k), 0, 0, "R11 accepted events");
      acc_in = 1'b1; acc_buf = 2'd0;
      @(negedge clk);
    end
    acc_in = 1'b0;
    chk(acc_ovf == 1'b1, "R11 flag set on drop", acc_ovf, 1);
    wait_idle();
    chk(acc_ovf == 1'b1, "R11 flag sticky", acc_ovf, 1);

    // R12: region without trailer, slow pace fills the FIFO
    rate_div = 8'd2;
    for (int k = 1; k <= 62; k++) expect_w(dw(3, k), 0, 0, "R12 trailerless region");
    acc_in = 1'b1; acc_buf = 2'd3;
    @(negedge clk);
    acc_in = 1'b0;
    wait_idle();
    chk(trl_info == 32'h3F3F3F3F, "R12 last word taken as trailer", trl_info, 32'h3F3F3F3F);
    chk(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule